// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for 48 pins, grouped into three banks of 16. A 16-bit register bus with a single-cycle write strobe and a combinational read port reaches every control register. Each bank has a direction mask, a polarity mask and an output latch. Software changes the output latch only through a write-one-to-set port and a write-one-to-clear port. Every pad input goes through a two-flop synchroniser. A read of the set port returns the synchronised, polarity-adjusted levels of that bank.

The sixteen pins of bank 0 can raise an interrupt. An edge-select bit makes a pin sensitive to both edges. When that bit is low, the pin's polarity bit picks the edge. A detected edge on an enabled pin latches a sticky pending bit, and the single interrupt line is high while any pending bit is set. Each pin also has a 2-bit function-select field, which is stored and driven out for an external pad multiplexer.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (all pins inputs, `pin_oe` all 0). The output latches, polarity masks, edge-select, interrupt-enable and pending registers are all 0, and `irq` is 0.
- R2: Pin n belongs to bank n/16 at bit n%16. Word addresses are: direction 0x00+b, polarity 0x04+b, set port 0x08+b, clear port 0x0C+b (b = bank), interrupt enable 0x10, edge select 0x11, pending 0x12, and function-select word k at 0x18+k. Unmapped reads return 0.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` 0). A 0 makes it an output (`pin_oe` 1), from the edge after the write.
- R4: Writing the set port sets the latch bits that are 1 in the data. Bits written as 0 leave their latch bits unchanged.
- R5: Writing the clear port clears the latch bits that are 1 in the data. Bits written as 0 leave their latch bits unchanged.
- R6: `pin_out` of each pin is its latch bit XOR its polarity bit.
- R7: A read of the set port returns the pin level XOR the polarity bit. The level appears two clock edges after the pad changes. A read of the clear port returns the latch.
- R8: With edge select 0 and polarity 0, a falling edge on an enabled bank-0 pin sets its pending bit, and a rising edge does not.
- R9: With edge select 0 and polarity 1, a rising edge sets the pending bit, and a falling edge does not.
- R10: With edge select 1, both edges set the pending bit.
- R11: Edges on pins whose interrupt-enable bit is 0, and on any pin of banks 1 and 2, never set a pending bit or `irq`.
- R12: Pending bits stay set until a 1 is written to them at 0x12 (bits written as 0 are kept). `irq` is the OR of all pending bits. A pending bit is visible three edges after the pad edge.
- R13: Function-select word k holds the 2-bit fields of pins 8k..8k+7, with pin n at bits [2(n%8)+1:2(n%8)]. `func_sel[2n+1:2n]` carries the field of pin n. The words read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | Pad input levels |
| pin_out | output | 48 | Pad drive values |
| pin_oe | output | 48 | Pad output enables |
| func_sel | output | 96 | Function-select field per pin |
| irq | output | 1 | Interrupt, OR of pending bits |

## Verification
The bench builds the block with its default three banks and 2-bit select fields. With that build, pins in every bank can be driven, including a polarity mask on the top bank. Pins of a bank that cannot interrupt can be toggled to show that `irq` stays low. A field in a middle select word, the one for pin 23, is checked against its slice of `func_sel`. The interrupt pins cover all three edge modes, and the bench also measures the exact synchroniser latency of the readback path.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 6;

  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [3:0] {
    K_NONE, K_DIR, K_INV, K_SET, K_CLR, K_IRQEN, K_EDGE, K_PEND, K_FSEL
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  // Word-address decode: banked groups of four, then the interrupt trio,
  // then the select words from 0x18 upward.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.kind = K_NONE;
    s.idx  = {2'b00, a[1:0]};
    if (a[5:3] == 3'b011) begin
      s.kind = K_FSEL;
      s.idx  = {1'b0, a[2:0]};
    end else begin
      case (a[5:2])
        4'd0: s.kind = K_DIR;
        4'd1: s.kind = K_INV;
        4'd2: s.kind = K_SET;
        4'd3: s.kind = K_CLR;
        4'd4: begin
          case (a[1:0])
            2'd0:    s.kind = K_IRQEN;
            2'd1:    s.kind = K_EDGE;
            2'd2:    s.kind = K_PEND;
            default: s.kind = K_NONE;
          endcase
        end
        default: s.kind = K_NONE;
      endcase
    end
    return s;
  endfunction

  // Value seen on the pad for a latch/polarity pair.
  function automatic reg_t pad_level(input reg_t latch, input reg_t pol);
    return latch ^ pol;
  endfunction

  // Edge qualification: both-edge bit overrides, else polarity picks the edge.
  function automatic reg_t edge_hits(input reg_t prev, input reg_t cur,
                                     input reg_t pol, input reg_t both);
    reg_t rise;
    reg_t fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    return (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_dir,
  input  logic wr_inv,
  input  logic wr_set,
  input  logic wr_clr,
  input  reg_t wdata,
  output reg_t dir_q,
  output reg_t inv_q,
  output reg_t out_q,
  output reg_t pad_out,
  output reg_t pad_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      inv_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_inv) inv_q <= wdata;
      if (wr_set)      out_q <= out_q | wdata;
      else if (wr_clr) out_q <= out_q & ~wdata;
    end
  end

  assign pad_out = pad_level(out_q, inv_q);
  assign pad_oe  = ~dir_q;

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wdata)) == $past(wdata)));

  assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set) |=> ((out_q & $past(wdata)) == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr) |=> $stable(out_q));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t lvl,
  input  reg_t pol,
  input  logic wr_en,
  input  logic wr_edge,
  input  logic wr_pend,
  input  reg_t wdata,
  output reg_t en_q,
  output reg_t both_q,
  output reg_t pend_q,
  output reg_t hit,
  output logic irq
);
  reg_t prev_q;
  reg_t clr_mask;

  assign hit      = edge_hits(prev_q, lvl, pol, both_q) & en_q;
  assign clr_mask = wr_pend ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      en_q   <= '0;
      both_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      if (wr_en)   en_q   <= wdata;
      if (wr_edge) both_q <= wdata;
      pend_q <= (pend_q & ~clr_mask) | hit;
    end
  end

  assign irq = |pend_q;

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_mask) & ~pend_q) == '0));

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  assert_irq_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_pend));
endmodule

// File: rtl/gpio_fsel.sv
module gpio_fsel
  import gpio_pkg::*;
#(
  parameter int NREG = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [3:0]            idx,
  input  reg_t                  wdata,
  output reg_t [NREG-1:0]       words,
  output logic [NREG*REG_W-1:0] flat
);
  for (genvar k = 0; k < NREG; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    words[k] <= '0;
      else if (wr && idx == 4'(k))   words[k] <= wdata;
    end
    assign flat[k*REG_W +: REG_W] = words[k];
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int FSEL_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [5:0]                  bus_addr,
  input  logic                        bus_wr,
  input  logic [15:0]                 bus_wdata,
  output logic [15:0]                 bus_rdata,
  input  logic [NUM_BANKS*16-1:0]     pin_in,
  output logic [NUM_BANKS*16-1:0]     pin_out,
  output logic [NUM_BANKS*16-1:0]     pin_oe,
  output logic [NUM_BANKS*16*FSEL_W-1:0] func_sel,
  output logic                        irq
);
  localparam int PINS = NUM_BANKS * REG_W;
  localparam int NREG = (PINS * FSEL_W + REG_W - 1) / REG_W;

  reg_sel_t sel;
  assign sel = decode_addr(bus_addr);

  logic [PINS-1:0] sync_lvl;
  reg_t [NUM_BANKS-1:0] dir_v, inv_v, out_v;

  gpio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_b;
    assign hit_b = (sel.idx == 4'(b));
    gpio_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (bus_wr && sel.kind == K_DIR && hit_b),
      .wr_inv (bus_wr && sel.kind == K_INV && hit_b),
      .wr_set (bus_wr && sel.kind == K_SET && hit_b),
      .wr_clr (bus_wr && sel.kind == K_CLR && hit_b),
      .wdata  (bus_wdata),
      .dir_q  (dir_v[b]),
      .inv_q  (inv_v[b]),
      .out_q  (out_v[b]),
      .pad_out(pin_out[b*REG_W +: REG_W]),
      .pad_oe (pin_oe[b*REG_W +: REG_W])
    );
  end

  reg_t en_v, both_v, pend_v, hit_v;
  gpio_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (sync_lvl[REG_W-1:0]),
    .pol    (inv_v[0]),
    .wr_en  (bus_wr && sel.kind == K_IRQEN),
    .wr_edge(bus_wr && sel.kind == K_EDGE),
    .wr_pend(bus_wr && sel.kind == K_PEND),
    .wdata  (bus_wdata),
    .en_q   (en_v),
    .both_q (both_v),
    .pend_q (pend_v),
    .hit    (hit_v),
    .irq    (irq)
  );

  reg_t [NREG-1:0] fs_words;
  logic [NREG*REG_W-1:0] fs_flat;
  gpio_fsel #(.NREG(NREG)) u_fsel (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (bus_wr && sel.kind == K_FSEL),
    .idx  (sel.idx),
    .wdata(bus_wdata),
    .words(fs_words),
    .flat (fs_flat)
  );
  assign func_sel = fs_flat[PINS*FSEL_W-1:0];

  always_comb begin
    bus_rdata = '0;
    case (sel.kind)
      K_IRQEN: bus_rdata = en_v;
      K_EDGE:  bus_rdata = both_v;
      K_PEND:  bus_rdata = pend_v;
      K_FSEL: begin
        for (int k = 0; k < NREG; k++)
          if (sel.idx == 4'(k)) bus_rdata = fs_words[k];
      end
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (sel.idx == 4'(b)) begin
            case (sel.kind)
              K_DIR:   bus_rdata = dir_v[b];
              K_INV:   bus_rdata = inv_v[b];
              K_SET:   bus_rdata = pad_level(sync_lvl[b*REG_W +: REG_W], inv_v[b]);
              K_CLR:   bus_rdata = out_v[b];
              default: bus_rdata = '0;
            endcase
          end
        end
      end
    endcase
  end

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit_v) != '0));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [47:0] pins = '0;
  logic [47:0] pin_out, pin_oe;
  logic [95:0] func_sel;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .func_sel(func_sel), .irq(irq)
  );

  // {addr, wdata, bank to check, expected pin_out slice, expected pin_oe slice}
  localparam logic [55:0] VEC [10] = '{
    {6'h00, 16'h00FF, 2'd0, 16'h0000, 16'hFF00},
    {6'h08, 16'h0F0F, 2'd0, 16'h0F0F, 16'hFF00},
    {6'h08, 16'h0000, 2'd0, 16'h0F0F, 16'hFF00},
    {6'h0C, 16'h0103, 2'd0, 16'h0E0C, 16'hFF00},
    {6'h04, 16'h00F0, 2'd0, 16'h0EFC, 16'hFF00},
    {6'h01, 16'h0000, 2'd1, 16'h0000, 16'hFFFF},
    {6'h09, 16'h8001, 2'd1, 16'h8001, 16'hFFFF},
    {6'h0D, 16'hFFFE, 2'd1, 16'h0001, 16'hFFFF},
    {6'h06, 16'hFFFF, 2'd2, 16'hFFFF, 16'h0000},
    {6'h0A, 16'h1234, 2'd2, 16'hEDCB, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk);
    pins[n] = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 32'(pin_oe[31:0]), 32'h0);
    chk("R1 out", 32'(pin_out[31:0]), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(6'h00, v); chk("R1 dir", 32'(v), 32'hFFFF);
    rd(6'h12, v); chk("R1 pend", 32'(v), 32'h0);
    rd(6'h0C, v); chk("R1 latch", 32'(v), 32'h0);

    // Output path table: R2 R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      logic [1:0] bk;
      bk = VEC[i][33:32];
      wr(VEC[i][55:50], VEC[i][49:34]);
      chk($sformatf("R2 R4 R5 R6 out vec %0d", i), 32'(pin_out[bk*16 +: 16]), 32'(VEC[i][31:16]));
      chk($sformatf("R3 oe vec %0d", i), 32'(pin_oe[bk*16 +: 16]), 32'(VEC[i][15:0]));
    end
    rd(6'h20, v); chk("R2 unmapped", 32'(v), 32'h0);

    // R7 readback latency and polarity
    @(negedge clk);
    pins[31:16] = 16'hA5A5;
    @(negedge clk);
    rd(6'h09, v); chk("R7 one edge", 32'(v), 32'h0);
    @(negedge clk);
    rd(6'h09, v); chk("R7 two edges", 32'(v), 32'hA5A5);
    wr(6'h05, 16'h00FF);
    rd(6'h09, v); chk("R7 inverted", 32'(v), 32'hA55A);
    rd(6'h0D, v); chk("R7 latch read", 32'(v), 32'h0001);
    chk("R6 bank1 drive", 32'(pin_out[31:16]), 32'h00FE);

    // Interrupts: pin2 both edges, pins 0..4 enabled; bank0 polarity 0x00F0
    wr(6'h11, 16'h0004);
    wr(6'h10, 16'h001F);
    set_pin(0, 1'b1);
    rd(6'h12, v); chk("R8 rise ignored", 32'(v), 32'h0);
    set_pin(0, 1'b0);
    rd(6'h12, v); chk("R8 fall pend", 32'(v), 32'h0001);
    chk("R12 irq high", 32'(irq), 32'h1);
    repeat (5) @(negedge clk);
    rd(6'h12, v); chk("R12 sticky", 32'(v), 32'h0001);
    wr(6'h12, 16'h0000);
    rd(6'h12, v); chk("R12 zero write keeps", 32'(v), 32'h0001);
    wr(6'h12, 16'h0001);
    rd(6'h12, v); chk("R12 cleared", 32'(v), 32'h0);
    chk("R12 irq low", 32'(irq), 32'h0);

    set_pin(4, 1'b1);
    rd(6'h12, v); chk("R9 rise pend", 32'(v), 32'h0010);
    wr(6'h12, 16'h0010);
    set_pin(4, 1'b0);
    rd(6'h12, v); chk("R9 fall ignored", 32'(v), 32'h0);

    set_pin(2, 1'b1);
    rd(6'h12, v); chk("R10 rise", 32'(v), 32'h0004);
    wr(6'h12, 16'h0004);
    set_pin(2, 1'b0);
    rd(6'h12, v); chk("R10 fall", 32'(v), 32'h0004);
    wr(6'h12, 16'h0004);

    set_pin(5, 1'b1);
    rd(6'h12, v); chk("R11 disabled pin", 32'(v), 32'h0);
    set_pin(20, 1'b1);
    set_pin(20, 1'b0);
    set_pin(40, 1'b1);
    chk("R11 upper banks irq", 32'(irq), 32'h0);
    rd(6'h12, v); chk("R11 upper banks pend", 32'(v), 32'h0);

    // R13 function select
    wr(6'h1A, 16'hC000);
    chk("R13 pin23 field", 32'(func_sel[47:46]), 32'h3);
    rd(6'h1A, v); chk("R13 readback", 32'(v), 32'hC000);
    wr(6'h18, 16'h0002);
    chk("R13 pin0 field", 32'(func_sel[1:0]), 32'h2);
    chk("R13 neighbour", 32'(func_sel[3:2]), 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule